// File: doc/BRIEF.md
# Immediate-Add and Logical Execute Unit

This block is a one-stage 64-bit execute slice for three integer operations: an upper-immediate add, a bitwise AND, and an AND with the second operand inverted. It decodes a 32-bit instruction word. It publishes the two register indices it needs, so that an external register file can return the operand values in the same cycle. It then registers a write-back request and a request to squash the next instruction.

Instructions enter on a valid/ready stream, and results leave on another. The output stage holds one result. A new instruction is taken only when that stage is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` is low. The instruction word and both operand values must be held steady while `in_valid` is high and `in_ready` is low. A beat is transferred on a rising edge where valid and ready are both high.

The squash condition is a reduced model. It can test for "never", "result is zero" or "result is non-zero". It can invert the test, and it can apply the test to the low half of the result or to the whole result.

Top module: `immlog_exec`

## Requirements
- R1: A transfer in (`in_valid` and `in_ready` both high at a rising edge) makes `out_valid` high after that edge. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output field stays unchanged. Results leave in the order the instructions were accepted.
- R2: The operation is taken from instruction bits [31:26]. The value 0x0A selects the upper-immediate add. The value 0x02 selects a logical operation, but only when bits [11:10], [8] and [7:6] are all zero. Any other word still yields one result beat, with `out_wr_en` and `out_nullify` both low.
- R3: Upper-immediate add, first step: a 21-bit value is assembled from bits [20:0]. Assembled bit i is source bit IMM_PERM[5i+4:5i]. The assembled value is placed in bits [31:11] with bits [10:0] zero, and it is sign extended from bit 31 to 64 bits.
- R4: Upper-immediate add, second step: the immediate from R3 is added modulo 2^64 to the operand whose index is bits [25:21]. The sum is written to register 1 with `out_wr_en` high and `out_nullify` low, whatever the other bits of the word hold.
- R5: Logical operation: operand A has index bits [20:16] and operand B has index bits [25:21]. Bit [9] = 1 gives A AND B. Bit [9] = 0 gives A AND NOT B. The destination is bits [4:0].
- R6: Logical squash condition: bits [15:13] select 0 = never, 1 = result is zero, 2 = result is non-zero, and 3 to 7 = never. Bit [12] inverts the outcome, and `out_nullify` carries the final outcome.
- R7: Bit [5] picks the width of the zero test: 1 tests all 64 result bits, and 0 tests only bits [31:0].
- R8: An operand whose index is 0 reads as zero, whatever value is supplied. A logical result with destination 0 has `out_wr_en` low, but its `out_nullify` still follows R6.
- R9: `rd_idx_a` is bits [25:21] for opcode 0x0A and bits [20:16] otherwise. `rd_idx_b` is bits [25:21]. Both follow `in_insn` in the same cycle.
- R10: While `rst_n` is low, `out_valid` is low and `in_ready` is high.
- R11: An upper-immediate add whose sum overflows wraps silently and raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 64 | Value of register `rd_idx_a` |
| in_opb | input | 64 | Value of register `rd_idx_b` |
| rd_idx_a | output | 5 | Index of the first operand |
| rd_idx_b | output | 5 | Index of the second operand |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result |
| out_wr_en | output | 1 | Write-back requested |
| out_wr_idx | output | 5 | Destination register index |
| out_wr_data | output | 64 | Value to write |
| out_nullify | output | 1 | Squash the following instruction |

## Verification
The bench builds the unit with XLEN = 64 and with a non-identity immediate permutation: assembled bit i takes source bit (8·i) mod 21. A miswired or reversed permutation therefore changes the results, which the identity default would hide. Pseudo-random back-pressure on `out_ready` exercises the hold and ordering rules. Chosen operand pairs give results that are zero only in the low half, so the 32-bit and 64-bit zero tests give different outcomes.

// File: rtl/immlog_pkg.sv
package immlog_pkg;
  localparam int INSN_W  = 32;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 21;
  localparam int SHAMT   = 11;
  localparam int PERM_W  = IMM_W * IDX_W;

  localparam logic [5:0] OPC_UPADD = 6'h0A;
  localparam logic [5:0] OPC_LOGIC = 6'h02;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_UPADD,
    OP_AND,
    OP_ANDNOT
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [IDX_W-1:0] idx_a;
    logic [IDX_W-1:0] idx_b;
    logic [IDX_W-1:0] dest;
    logic [IMM_W-1:0] imm_raw;
    logic [2:0]       cond;
    logic             inv;
    logic             wide;
  } dec_t;

  function automatic logic [PERM_W-1:0] identity_perm();
    logic [PERM_W-1:0] p;
    for (int i = 0; i < IMM_W; i++) p[i*IDX_W +: IDX_W] = IDX_W'(i);
    return p;
  endfunction
endpackage

// File: rtl/immlog_decode.sv
module immlog_decode
  import immlog_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  logic [5:0] opc;
  logic       ext_ok;

  assign opc    = insn[31:26];
  assign ext_ok = (insn[11:10] == 2'b00) && !insn[8] && (insn[7:6] == 2'b00);

  always_comb begin
    dec = '0;
    if (opc == OPC_UPADD)                dec.op = OP_UPADD;
    else if (opc == OPC_LOGIC && ext_ok) dec.op = insn[9] ? OP_AND : OP_ANDNOT;
    else                                 dec.op = OP_NONE;
    dec.idx_a   = (opc == OPC_UPADD) ? insn[25:21] : insn[20:16];
    dec.idx_b   = insn[25:21];
    dec.dest    = (opc == OPC_UPADD) ? IDX_W'(1) : insn[4:0];
    dec.imm_raw = insn[20:0];
    dec.cond    = insn[15:13];
    dec.inv     = insn[12];
    dec.wide    = insn[5];
  end
endmodule

// File: rtl/immlog_imm.sv
module immlog_imm
  import immlog_pkg::*;
#(
  parameter int                XLEN     = 64,
  parameter logic [PERM_W-1:0] IMM_PERM = immlog_pkg::identity_perm()
) (
  input  logic [IMM_W-1:0] raw,
  output logic [XLEN-1:0]  value
);
  localparam int EXT_W = XLEN - IMM_W - SHAMT;

  logic [IMM_W-1:0] asm_imm;

  for (genvar i = 0; i < IMM_W; i++) begin : g_perm
    assign asm_imm[i] = raw[IMM_PERM[i*IDX_W +: IDX_W]];
  end

  assign value = {{EXT_W{asm_imm[IMM_W-1]}}, asm_imm, {SHAMT{1'b0}}};
endmodule

// File: rtl/immlog_cond.sv
module immlog_cond #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val,
  input  logic [2:0]      cond,
  input  logic            inv,
  input  logic            wide,
  output logic            hit
);
  localparam int HALF = XLEN / 2;

  logic lo_zero, hi_zero, is_zero, base;

  assign lo_zero = ~|val[HALF-1:0];
  assign hi_zero = ~|val[XLEN-1:HALF];
  assign is_zero = wide ? (lo_zero & hi_zero) : lo_zero;

  always_comb begin
    unique case (cond)
      3'd1:    base = is_zero;
      3'd2:    base = !is_zero;
      default: base = 1'b0;
    endcase
  end

  assign hit = base ^ inv;
endmodule

// File: rtl/immlog_alu.sv
module immlog_alu
  import immlog_pkg::*;
#(
  parameter int                XLEN     = 64,
  parameter logic [PERM_W-1:0] IMM_PERM = immlog_pkg::identity_perm()
) (
  input  dec_t              dec,
  input  logic [XLEN-1:0]   opa_raw,
  input  logic [XLEN-1:0]   opb_raw,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic              nullify
);
  logic [XLEN-1:0] opa, opb, imm_val, res;
  logic            hit, is_logic;

  assign opa = (dec.idx_a == '0) ? '0 : opa_raw;
  assign opb = (dec.idx_b == '0) ? '0 : opb_raw;

  immlog_imm #(.XLEN(XLEN), .IMM_PERM(IMM_PERM)) u_imm (
    .raw   (dec.imm_raw),
    .value (imm_val)
  );

  always_comb begin
    unique case (dec.op)
      OP_UPADD:  res = opa + imm_val;
      OP_AND:    res = opa & opb;
      OP_ANDNOT: res = opa & ~opb;
      default:   res = '0;
    endcase
  end

  immlog_cond #(.XLEN(XLEN)) u_cond (
    .val  (res),
    .cond (dec.cond),
    .inv  (dec.inv),
    .wide (dec.wide),
    .hit  (hit)
  );

  assign is_logic = (dec.op == OP_AND) || (dec.op == OP_ANDNOT);
  assign nullify  = is_logic && hit;
  assign wr_en    = (dec.op != OP_NONE) && (dec.dest != '0);
  assign wr_idx   = dec.dest;
  assign wr_data  = res;
endmodule

// File: rtl/immlog_exec.sv
module immlog_exec
  import immlog_pkg::*;
#(
  parameter int                XLEN     = 64,
  parameter logic [PERM_W-1:0] IMM_PERM = immlog_pkg::identity_perm()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [XLEN-1:0]   in_opa,
  input  logic [XLEN-1:0]   in_opb,
  output logic [IDX_W-1:0]  rd_idx_a,
  output logic [IDX_W-1:0]  rd_idx_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wr_en,
  output logic [IDX_W-1:0]  out_wr_idx,
  output logic [XLEN-1:0]   out_wr_data,
  output logic              out_nullify
);
  dec_t             dec;
  logic             alu_wr_en, alu_nul, take;
  logic [IDX_W-1:0] alu_wr_idx;
  logic [XLEN-1:0]  alu_wr_data;

  immlog_decode u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  assign rd_idx_a = dec.idx_a;
  assign rd_idx_b = dec.idx_b;

  immlog_alu #(.XLEN(XLEN), .IMM_PERM(IMM_PERM)) u_alu (
    .dec     (dec),
    .opa_raw (in_opa),
    .opb_raw (in_opb),
    .wr_en   (alu_wr_en),
    .wr_idx  (alu_wr_idx),
    .wr_data (alu_wr_data),
    .nullify (alu_nul)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wr_en   <= 1'b0;
      out_wr_idx  <= '0;
      out_wr_data <= '0;
      out_nullify <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_wr_en   <= alu_wr_en;
      out_wr_idx  <= alu_wr_idx;
      out_wr_data <= alu_wr_data;
      out_nullify <= alu_nul;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_wr_en) && $stable(out_wr_idx)
                                   && $stable(out_wr_data) && $stable(out_nullify)));

  assert_upadd_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.op == OP_UPADD) |-> (alu_wr_en && alu_wr_idx == IDX_W'(1) && !alu_nul));

  assert_never_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (dec.op == OP_AND || dec.op == OP_ANDNOT) && dec.cond == 3'd0 && !dec.inv)
      |-> !alu_nul);

  assert_no_r0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr_en) |-> (out_wr_idx != '0));
endmodule

// File: tb/test_immlog_exec.sv
module test_immlog_exec;
  localparam int XLEN = 64;

  function automatic logic [104:0] stride_perm();
    logic [104:0] p;
    for (int i = 0; i < 21; i++) p[i*5 +: 5] = 5'((i * 8) % 21);
    return p;
  endfunction
  localparam logic [104:0] PERM = stride_perm();

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 1;
  logic [31:0] in_insn = '0;
  logic [63:0] in_opa = '0, in_opb = '0;
  logic in_ready, out_valid, out_wr_en, out_nullify;
  logic [4:0] rd_idx_a, rd_idx_b, out_wr_idx;
  logic [63:0] out_wr_data;

  always #5 clk = ~clk;

  immlog_exec #(.XLEN(XLEN), .IMM_PERM(PERM)) i_immlog_exec (
    .clk, .rst_n, .in_valid, .in_ready, .in_insn, .in_opa, .in_opb,
    .rd_idx_a, .rd_idx_b, .out_valid, .out_ready, .out_wr_en,
    .out_wr_idx, .out_wr_data, .out_nullify
  );

  typedef struct {
    logic        we;
    logic [4:0]  idx;
    logic [63:0] data;
    logic        nul;
    string       tag;
  } exp_t;

  exp_t expq[$];
  exp_t mon_e;
  int checks = 0, failures = 0;
  logic bp_on = 0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;
  logic [15:0] bp_lfsr = 16'hACE1;
  bit done = 0;

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] x = s;
    x ^= x << 13; x ^= x >> 7; x ^= x << 17;
    return x;
  endfunction

  function automatic logic [31:0] enc_up(input logic [4:0] r, input logic [20:0] im);
    return {6'h0A, r, im};
  endfunction

  function automatic logic [31:0] enc_lg(input logic plain, input logic [4:0] r2, input logic [4:0] r1,
                                         input logic [2:0] c, input logic f, input logic d,
                                         input logic [4:0] t);
    return {6'h02, r2, r1, c, f, 2'b00, plain, 1'b0, 2'b00, d, t};
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [63:0] a_in, input logic [63:0] b_in);
    exp_t e;
    logic [20:0] asm_i;
    logic [63:0] a, b, res;
    logic z, base;
    e.we = 0; e.idx = '0; e.data = '0; e.nul = 0; e.tag = "";
    if (w[31:26] == 6'h0A) begin
      a = (w[25:21] == 0) ? 64'd0 : a_in;
      for (int i = 0; i < 21; i++) asm_i[i] = w[(i * 8) % 21];
      e.data = a + {{32{asm_i[20]}}, asm_i, 11'd0};
      e.we = 1; e.idx = 5'd1;
    end else if (w[31:26] == 6'h02 && w[11:10] == 0 && !w[8] && w[7:6] == 0) begin
      a = (w[20:16] == 0) ? 64'd0 : a_in;
      b = (w[25:21] == 0) ? 64'd0 : b_in;
      res = w[9] ? (a & b) : (a & ~b);
      z = w[5] ? (res == 0) : (res[31:0] == 0);
      base = (w[15:13] == 1) ? z : (w[15:13] == 2) ? !z : 1'b0;
      e.nul = base ^ w[12];
      e.idx = w[4:0];
      e.we = (w[4:0] != 0);
      e.data = res;
    end
    return e;
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic send(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b, input string tag);
    exp_t e;
    logic [4:0] ea;
    @(negedge clk);
    in_insn = w; in_opa = a; in_opb = b; in_valid = 1;
    #1;
    ea = (w[31:26] == 6'h0A) ? w[25:21] : w[20:16];
    checks++;
    if (rd_idx_a !== ea || rd_idx_b !== w[25:21]) begin
      failures++;
      $display("FAIL R9 rd_idx a=%0d b=%0d expected a=%0d b=%0d", rd_idx_a, rd_idx_b, ea, w[25:21]);
    end
    while (!in_ready) begin @(negedge clk); #1; end
    e = model(w, a, b);
    e.tag = tag;
    expq.push_back(e);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R1 unexpected beat we=%0b idx=%0d expected no beat", out_wr_en, out_wr_idx);
      end else begin
        mon_e = expq[0];
        if (out_wr_en !== mon_e.we || out_nullify !== mon_e.nul ||
            (mon_e.we && (out_wr_idx !== mon_e.idx || out_wr_data !== mon_e.data))) begin
          failures++;
          $display("FAIL %s actual we=%0b idx=%0d data=%h nul=%0b expected we=%0b idx=%0d data=%h nul=%0b",
                   mon_e.tag, out_wr_en, out_wr_idx, out_wr_data, out_nullify,
                   mon_e.we, mon_e.idx, mon_e.data, mon_e.nul);
        end
        if (out_ready) void'(expq.pop_front());
      end
    end
  end

  initial begin
    wait (rst_n);
    forever begin
      @(posedge clk); #1;
      bp_lfsr = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
      out_ready = bp_on ? (bp_lfsr[0] | bp_lfsr[3]) : 1'b1;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [63:0] a, b;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R10 reset out_valid=%0b in_ready=%0b expected 0/1", out_valid, in_ready);
    end
    @(negedge clk); rst_n = 1;

    // R3 R4: positive and negative assembled immediates
    send(enc_up(5'd3, 21'h0_1234), 64'h0000_0001_0000_0000, 64'h55, "R3 R4 up-add positive");
    send(enc_up(5'd7, 21'h1F_FFFF), 64'h10, 64'h0, "R3 up-add all-ones immediate");
    send(enc_up(5'd9, 21'h0_2000), 64'h1234, 64'h0, "R3 up-add single source bit");
    // R11: wrap-around
    send(enc_up(5'd4, 21'h0_0001), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R11 up-add wrap");
    // R8: index zero reads as zero
    send(enc_up(5'd0, 21'h0_00FF), 64'hDEAD_BEEF, 64'h0, "R8 up-add source r0");
    // R5: AND and AND-not
    send(enc_lg(1, 5'd2, 5'd3, 3'd0, 0, 1, 5'd6), 64'hFF00_FF00_1234_5678, 64'h0FF0_0FF0_FFFF_0000, "R5 and");
    send(enc_lg(0, 5'd2, 5'd3, 3'd0, 0, 1, 5'd6), 64'hFF00_FF00_1234_5678, 64'h0FF0_0FF0_FFFF_0000, "R5 and-not");
    // R6 R7: low half zero, upper not zero
    send(enc_lg(1, 5'd2, 5'd3, 3'd1, 0, 0, 5'd8), 64'hFFFF_0000_0000_0000, 64'hFFFF_FFFF_0000_0000, "R7 zero test low half");
    send(enc_lg(1, 5'd2, 5'd3, 3'd1, 0, 1, 5'd8), 64'hFFFF_0000_0000_0000, 64'hFFFF_FFFF_0000_0000, "R7 zero test full width");
    send(enc_lg(1, 5'd2, 5'd3, 3'd2, 0, 1, 5'd8), 64'hFFFF_0000_0000_0000, 64'hFFFF_FFFF_0000_0000, "R6 non-zero test");
    send(enc_lg(0, 5'd2, 5'd3, 3'd0, 1, 1, 5'd8), 64'h1, 64'h1, "R6 inverted never");
    send(enc_lg(1, 5'd2, 5'd3, 3'd5, 0, 1, 5'd8), 64'h0, 64'h0, "R6 unmodelled code");
    // R8: destination zero and operand index zero
    send(enc_lg(1, 5'd2, 5'd3, 3'd1, 0, 1, 5'd0), 64'h0, 64'hF, "R8 dest r0 still squashes");
    send(enc_lg(1, 5'd0, 5'd3, 3'd2, 0, 1, 5'd9), 64'hFFFF, 64'hFFFF, "R8 operand r0");
    // R2: rejected words
    send(enc_lg(1, 5'd2, 5'd3, 3'd2, 0, 1, 5'd9) | 32'h0000_0100, 64'h1, 64'h1, "R2 bad extension bit");
    send({6'h2A, 26'h3FF_FFFF}, 64'h1, 64'h1, "R2 unknown opcode");

    // R1: random mix under back-pressure
    bp_on = 1;
    for (int n = 0; n < 120; n++) begin
      rs = nxt(rs); a = rs;
      rs = nxt(rs); b = rs;
      if (rs[7:6] == 2'b00) b = ~a;
      rs = nxt(rs);
      case (rs[1:0])
        2'd0: w = enc_up(rs[6:2], rs[27:7]);
        2'd1: w = enc_lg(1, rs[6:2], rs[11:7], {1'b0, rs[13:12]}, rs[14], rs[15], rs[20:16]);
        2'd2: w = enc_lg(0, rs[6:2], rs[11:7], {1'b0, rs[13:12]}, rs[14], rs[15], rs[20:16]);
        default: w = rs[63:32];
      endcase
      send(w, a, b, "R1 R5 R6 random under back-pressure");
    end
    bp_on = 0;

    for (int k = 0; k < 200 && expq.size() != 0; k++) @(posedge clk);
    repeat (3) @(negedge clk);
    checks++;
    if (expq.size() != 0 || out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 drain pending=%0d out_valid=%0b expected 0/0", expq.size(), out_valid);
    end
    done = 1;
    report();
    $finish;
  end
endmodule